// File: doc/BRIEF.md
# Nibble-Coded Stored-Program Processor

This block is a compact multicycle processor. Program and data share one internal memory of 256 cells, each 16 bits wide. The processor works through a strict three-phase cycle. In the first phase it reads the cell named by the program counter into the instruction register and advances the counter by one. In the second phase it reads the source registers into operand latches. In the third phase it carries out the instruction. Every instruction is one 16-bit word. The top nibble selects one of sixteen operations, and the three lower nibbles act as register numbers, as a shift count or, taken as a pair, as an 8-bit cell address or constant.

A host port is used to prepare a run. While reset is held, the host writes the whole memory image through this port. Once reset is released, execution starts at cell 0 and continues until a halt instruction. After the halt the processor raises `halted` and stays frozen until the next reset. A combinational read path onto memory and a second one onto the register file let the host inspect results at any time.

Top module: `nibble_cpu`

## Requirements
- R1: Reset sets the program counter and all sixteen registers to zero and clears `halted`. A host write (`hst_we`) reaches memory only while `rst_n` is low. A host write with `rst_n` high leaves memory unchanged.
- R2: The opcode sits in instruction bits [15:12]. The first operand nibble R is in [11:8], the second S (or X) is in [7:4] and the third T (or Y) is in [3:0]. The pair XY in [7:0] is an address or a constant.
- R3: Opcode 1 loads register R from memory cell XY. Opcode 2 loads register R with XY zero-extended to 16 bits.
- R4: Opcode 3 writes register R into memory cell XY.
- R5: Opcode 4 (form 0RS) copies register R, taken from [7:4], into register S, taken from [3:0].
- R6: Opcode 5 writes the sum of registers S and T into R, modulo 2^16.
- R7: Opcodes 7, 8 and 9 write the bitwise OR, AND and XOR of registers S and T into R, in that order.
- R8: Opcode A (form R0X) rotates register R right by X positions, where X is in [3:0]. A count of 0 leaves the register unchanged.
- R9: Opcode B loads the program counter with XY when register R equals register 0. Otherwise execution goes on with the next cell.
- R10: Opcode D (form 0XY) loads the program counter with XY unconditionally.
- R11: Opcode C halts execution. After the halt `halted` stays high, and the program counter, registers and memory do not change until reset.
- R12: Opcodes 0, 6, E and F change no register or memory cell. They only advance the program counter.
- R13: Every instruction, halt included, takes exactly three clock cycles: fetch, decode and execute. `halted` rises after the third cycle of the halt, and `pc_o` then points one cell past the halt.
- R14: A store that writes the cell holding the next instruction takes effect before that instruction is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; also opens the host write path |
| hst_we | input | 1 | Host memory write strobe, accepted only during reset |
| hst_addr | input | 8 | Host memory address for writes and reads |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Memory cell at `hst_addr`, combinational |
| reg_sel | input | 4 | Register number for inspection |
| reg_rdata | output | 16 | Contents of register `reg_sel`, combinational |
| pc_o | output | 8 | Current program counter |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
A memory write from a store and the fetch of the next instruction can land on the same cell in back-to-back cycles, with no gap between them. The bench provokes this with a program whose store overwrites the halt that follows it, putting a load-constant in its place. The result counts as correct only if the patched instruction runs: the target register holds the patched constant, and the cycle count shows one extra instruction before the halt.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;
    localparam int NREGS  = 16;
    localparam int RSEL_W = $clog2(NREGS);
    localparam int SHW    = $clog2(DATA_W);

    typedef enum logic [3:0] {
        OP_NOP0 = 4'h0,
        OP_LDM  = 4'h1,
        OP_LDI  = 4'h2,
        OP_STM  = 4'h3,
        OP_MOV  = 4'h4,
        OP_ADD  = 4'h5,
        OP_FADD = 4'h6,
        OP_OR   = 4'h7,
        OP_AND  = 4'h8,
        OP_XOR  = 4'h9,
        OP_ROR  = 4'hA,
        OP_JEQ  = 4'hB,
        OP_HLT  = 4'hC,
        OP_JMP  = 4'hD,
        OP_RSVE = 4'hE,
        OP_RSVF = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2,
        ST_HALT   = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [ADDR_W-1:0]   pc;
        logic [DATA_W-1:0]   ir;
        logic [DATA_W-1:0]   opa;
        logic [DATA_W-1:0]   opb;
    } ctl_t;

endpackage

// File: rtl/cpu_mem.sv
module cpu_mem #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_we,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (cpu_we) begin
            cells_q[cpu_addr] <= cpu_wdata;
        end else if (host_we) begin
            cells_q[host_addr] <= host_wdata;
        end
    end

    assign cpu_rdata  = cells_q[cpu_addr];
    assign host_rdata = cells_q[host_addr];

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int DW = 16,
    parameter int NR = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [$clog2(NR)-1:0]  waddr,
    input  logic [DW-1:0]          wdata,
    input  logic [$clog2(NR)-1:0]  ra_addr,
    output logic [DW-1:0]          ra_data,
    input  logic [$clog2(NR)-1:0]  rb_addr,
    output logic [DW-1:0]          rb_data,
    input  logic [$clog2(NR)-1:0]  rc_addr,
    output logic [DW-1:0]          rc_data
);
    localparam int RAW = $clog2(NR);

    logic [DW-1:0] rf_q [NR];
    logic [DW-1:0] rf_d [NR];

    always_comb begin
        for (int i = 0; i < NR; i++) begin
            rf_d[i] = (we && waddr == RAW'(i)) ? wdata : rf_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) begin
                rf_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NR; i++) begin
                rf_q[i] <= rf_d[i];
            end
        end
    end

    assign ra_data = rf_q[ra_addr];
    assign rb_data = rf_q[rb_addr];
    assign rc_data = rf_q[rc_addr];

    // R5 / R6 / R7: a write-back lands in the addressed register
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> rf_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int DW = 16
) (
    input  opcode_e                 op,
    input  logic [DW-1:0]           a,
    input  logic [DW-1:0]           b,
    input  logic [$clog2(DW)-1:0]   sh,
    input  logic [7:0]              imm,
    input  logic [DW-1:0]           mem_data,
    output logic [DW-1:0]           result
);
    logic [2*DW-1:0] dbl;

    always_comb begin
        dbl = {a, a} >> sh;
        unique case (op)
            OP_LDM:  result = mem_data;
            OP_LDI:  result = {{(DW-8){1'b0}}, imm};
            OP_ADD:  result = a + b;
            OP_OR:   result = a | b;
            OP_AND:  result = a & b;
            OP_XOR:  result = a ^ b;
            OP_ROR:  result = dbl[DW-1:0];
            default: result = a;
        endcase
    end

endmodule

// File: rtl/nibble_cpu.sv
module nibble_cpu
    import cpu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hst_we,
    input  logic [ADDR_W-1:0]   hst_addr,
    input  logic [DATA_W-1:0]   hst_wdata,
    output logic [DATA_W-1:0]   hst_rdata,
    input  logic [RSEL_W-1:0]   reg_sel,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [ADDR_W-1:0]   pc_o,
    output logic                halted
);
    ctl_t ctl_q, ctl_d;

    opcode_e             op;
    logic [RSEL_W-1:0]   f_r, f_s, f_t;
    logic [ADDR_W-1:0]   f_xy;

    logic [RSEL_W-1:0]   ra_addr, rb_addr, rf_waddr;
    logic [DATA_W-1:0]   ra_data, rb_data, rf_wdata;
    logic                rf_we;

    logic [ADDR_W-1:0]   mem_addr;
    logic [DATA_W-1:0]   mem_rdata;
    logic                mem_we;
    logic                noop_op;

    // R2: instruction field split
    assign op   = opcode_e'(ctl_q.ir[15:12]);
    assign f_r  = ctl_q.ir[11:8];
    assign f_s  = ctl_q.ir[7:4];
    assign f_t  = ctl_q.ir[3:0];
    assign f_xy = ctl_q.ir[7:0];

    assign noop_op = (op == OP_NOP0) || (op == OP_FADD) ||
                     (op == OP_RSVE) || (op == OP_RSVF);

    always_comb begin
        unique case (op)
            OP_MOV, OP_ADD, OP_OR, OP_AND, OP_XOR: ra_addr = f_s;
            default:                               ra_addr = f_r;
        endcase
        rb_addr = (op == OP_JEQ) ? '0 : f_t;
    end

    cpu_regfile #(.DW(DATA_W), .NR(NREGS)) i_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .ra_addr (ra_addr),
        .ra_data (ra_data),
        .rb_addr (rb_addr),
        .rb_data (rb_data),
        .rc_addr (reg_sel),
        .rc_data (reg_rdata)
    );

    cpu_mem #(.DW(DATA_W), .AW(ADDR_W)) i_mem (
        .clk        (clk),
        .cpu_addr   (mem_addr),
        .cpu_we     (mem_we),
        .cpu_wdata  (ctl_q.opa),
        .cpu_rdata  (mem_rdata),
        .host_we    (hst_we && !rst_n),
        .host_addr  (hst_addr),
        .host_wdata (hst_wdata),
        .host_rdata (hst_rdata)
    );

    cpu_alu #(.DW(DATA_W)) i_alu (
        .op       (op),
        .a        (ctl_q.opa),
        .b        (ctl_q.opb),
        .sh       (f_t[SHW-1:0]),
        .imm      (f_xy),
        .mem_data (mem_rdata),
        .result   (rf_wdata)
    );

    always_comb begin
        ctl_d    = ctl_q;
        rf_we    = 1'b0;
        rf_waddr = f_r;
        mem_we   = 1'b0;
        mem_addr = f_xy;
        unique case (ctl_q.phase)
            ST_FETCH: begin
                mem_addr    = ctl_q.pc;
                ctl_d.ir    = mem_rdata;
                ctl_d.pc    = ctl_q.pc + 1'b1;
                ctl_d.phase = ST_DECODE;
            end
            ST_DECODE: begin
                ctl_d.opa   = ra_data;
                ctl_d.opb   = rb_data;
                ctl_d.phase = ST_EXEC;
            end
            ST_EXEC: begin
                ctl_d.phase = ST_FETCH;
                unique case (op)
                    OP_LDM, OP_LDI, OP_ADD, OP_OR, OP_AND, OP_XOR, OP_ROR:
                        rf_we = 1'b1;
                    OP_MOV: begin
                        rf_we    = 1'b1;
                        rf_waddr = f_t;
                    end
                    OP_STM: mem_we = 1'b1;
                    OP_JEQ: if (ctl_q.opa == ctl_q.opb) ctl_d.pc = f_xy;
                    OP_JMP: ctl_d.pc = f_xy;
                    OP_HLT: ctl_d.phase = ST_HALT;
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: ST_FETCH, pc: '0, ir: '0, opa: '0, opb: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pc_o   = ctl_q.pc;
    assign halted = (ctl_q.phase == ST_HALT);

    // R11: the halted state is held until reset
    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R11: no program counter motion and no store once halted
    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc_o) && !mem_we && !rf_we);

    // R13: fetch is followed by decode with the counter advanced by one
    a_r13_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == ST_FETCH) |=>
            (ctl_q.phase == ST_DECODE) && (pc_o == $past(pc_o) + 1'b1));

    // R9: an untaken compare keeps the sequential address
    a_r9_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == ST_EXEC && op == OP_JEQ && ctl_q.opa != ctl_q.opb)
            |=> pc_o == $past(pc_o));

    // R12: reserved and floating opcodes touch no storage
    a_r12_noop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == ST_EXEC && noop_op) |-> !rf_we && !mem_we);

endmodule

// File: tb/test_nibble_cpu.sv
module test_nibble_cpu;
    localparam int T = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_we = 1'b0;
    logic [7:0]  hst_addr = '0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic [3:0]  reg_sel = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  pc_o;
    logic        halted;

    logic [15:0] img [256];
    int n_vec = 0;
    int n_bad = 0;

    always #(T/2) clk = ~clk;

    nibble_cpu i_nibble_cpu (
        .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .reg_sel(reg_sel),
        .reg_rdata(reg_rdata), .pc_o(pc_o), .halted(halted)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rreg(input int idx, output logic [15:0] v);
        reg_sel = idx[3:0];
        #1;
        v = reg_rdata;
    endtask

    task automatic rmem(input int a, output logic [15:0] v);
        hst_addr = a[7:0];
        #1;
        v = hst_rdata;
    endtask

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 16'h0000;
    endtask

    // hold reset, write the whole image, release on a falling edge
    task automatic boot();
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            hst_we = 1'b1; hst_addr = i[7:0]; hst_wdata = img[i];
            @(negedge clk);
        end
        hst_we = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic run(output int cyc);
        cyc = 0;
        while (!halted && cyc < 30000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    function automatic logic [15:0] rotr(input logic [15:0] v, input int n);
        return (n == 0) ? v : ((v >> n) | (v << (16 - n)));
    endfunction

    task automatic t_reset();
        logic [15:0] v;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 halted in reset", {15'd0, halted}, 16'd0);
        chk("R1 pc in reset", {8'd0, pc_o}, 16'd0);
        for (int i = 0; i < 16; i++) begin
            rreg(i, v);
            chk("R1 register cleared", v, 16'd0);
        end
    endtask

    task automatic t_sample_add();
        int cyc;
        logic [15:0] v;
        clear_img();
        img[0] = 16'h1506; img[1] = 16'h1607; img[2] = 16'h5056;
        img[3] = 16'h3008; img[4] = 16'hC000;
        img[5] = 16'h0001; img[6] = 16'h0002; img[7] = 16'h0003;
        boot();
        run(cyc);
        chk("R13 cycles for five instructions", 16'(cyc), 16'd15);
        chk("R11 halted", {15'd0, halted}, 16'd1);
        chk("R13 pc after halt", {8'd0, pc_o}, 16'd5);
        rmem(8, v);  chk("R4 R6 sum stored", v, 16'h0005);
        rreg(5, v);  chk("R3 load from cell", v, 16'h0002);
        rreg(6, v);  chk("R3 load from cell", v, 16'h0003);
    endtask

    task automatic t_loop();
        int cyc;
        logic [15:0] v, m1, m2;
        clear_img();
        img[0] = 16'h20FF; img[1] = 16'h2102; img[2] = 16'h2200; img[3] = 16'h130A;
        img[4] = 16'h5223; img[5] = 16'h5110; img[6] = 16'hB108; img[7] = 16'hD004;
        img[8] = 16'h320A; img[9] = 16'hC000; img[10] = 16'h0003;
        m1 = 16'd2; m2 = 16'd0;
        do begin
            m2 = m2 + 16'd3;
            m1 = m1 + 16'h00FF;
        end while (m1 != 16'h00FF);
        boot();
        run(cyc);
        chk("R9 R10 loop terminates", {15'd0, halted}, 16'd1);
        rreg(2, v);  chk("R6 loop accumulator", v, m2);
        rreg(1, v);  chk("R9 counter equals r0", v, m1);
        rreg(0, v);  chk("R3 zero-extended constant", v, 16'h00FF);
        rmem(10, v); chk("R4 loop result stored", v, m2);
    endtask

    task automatic t_logic();
        int cyc;
        logic [15:0] v;
        clear_img();
        // R2: fields are op[15:12] R[11:8] S[7:4] T[3:0]
        img[0] = 16'h21F0; img[1] = 16'h223C; img[2] = 16'h7312; img[3] = 16'h8412;
        img[4] = 16'h9512; img[5] = 16'h4016; img[6] = 16'hA104; img[7] = 16'hA200;
        img[8] = 16'hA508; img[9] = 16'hA30F; img[10] = 16'h5855; img[11] = 16'h6123;
        img[12] = 16'h0123; img[13] = 16'hE123; img[14] = 16'hF123; img[15] = 16'hC000;
        boot();
        run(cyc);
        chk("R13 R12 cycles incl no-ops", 16'(cyc), 16'd48);
        chk("R12 pc after no-ops and halt", {8'd0, pc_o}, 16'd16);
        rreg(1, v); chk("R8 rotate by 4 and R12 untouched", v, rotr(16'h00F0, 4));
        rreg(2, v); chk("R8 rotate by 0", v, 16'h003C);
        rreg(3, v); chk("R7 OR then R8 rotate by 15", v, rotr(16'h00F0 | 16'h003C, 15));
        rreg(4, v); chk("R7 AND", v, 16'h00F0 & 16'h003C);
        rreg(5, v); chk("R7 XOR then R8 rotate by 8", v, rotr(16'h00F0 ^ 16'h003C, 8));
        rreg(6, v); chk("R5 move", v, 16'h00F0);
        rreg(8, v); chk("R6 add wraps", v, 16'((32'hCC00 + 32'hCC00) & 32'hFFFF));
        rreg(7, v); chk("R12 no write from no-op", v, 16'h0000);
    endtask

    task automatic t_jumps();
        int cyc;
        logic [15:0] v;
        clear_img();
        img[0] = 16'h2005; img[1] = 16'h2105; img[2] = 16'h2207; img[3] = 16'hB206;
        img[4] = 16'hB108; img[5] = 16'h23AA; img[6] = 16'hC000; img[7] = 16'hC000;
        img[8] = 16'h24BB; img[9] = 16'hD00C; img[10] = 16'h25EE; img[11] = 16'hC000;
        img[12] = 16'hB00E; img[13] = 16'h26DD; img[14] = 16'hC000;
        boot();
        run(cyc);
        chk("R9 R10 cycles on jump path", 16'(cyc), 16'd27);
        chk("R9 final pc", {8'd0, pc_o}, 16'd15);
        rreg(3, v); chk("R9 taken skips cell", v, 16'h0000);
        rreg(4, v); chk("R9 target executed", v, 16'h00BB);
        rreg(5, v); chk("R10 unconditional skip", v, 16'h0000);
        rreg(6, v); chk("R9 compare with r0 itself", v, 16'h0000);
    endtask

    task automatic t_halt_freeze();
        int cyc;
        logic [15:0] v;
        logic [7:0] pc_hold;
        clear_img();
        img[0] = 16'h2142; img[1] = 16'h3150; img[2] = 16'hC000;
        boot();
        run(cyc);
        pc_hold = pc_o;
        // R1: host writes with reset released must be dropped
        hst_we = 1'b1; hst_addr = 8'h50; hst_wdata = 16'hDEAD;
        @(negedge clk);
        hst_addr = 8'h00; hst_wdata = 16'hBEEF;
        @(negedge clk);
        hst_we = 1'b0;
        repeat (20) @(negedge clk);
        chk("R11 still halted", {15'd0, halted}, 16'd1);
        chk("R11 pc frozen", {8'd0, pc_o}, {8'd0, pc_hold});
        rmem(8'h50, v); chk("R1 R4 host write ignored while running", v, 16'h0042);
        rmem(0, v);     chk("R1 host write ignored while running", v, 16'h2142);
        rreg(1, v);     chk("R11 register unchanged", v, 16'h0042);
    endtask

    task automatic t_self_modify();
        int cyc;
        logic [15:0] v;
        clear_img();
        img[0] = 16'h110A; img[1] = 16'h3102; img[2] = 16'hC000; img[3] = 16'hC000;
        img[10] = 16'h27AB;
        boot();
        run(cyc);
        chk("R14 patched instruction ran", 16'(cyc), 16'd12);
        rreg(7, v);  chk("R14 patched constant loaded", v, 16'h00AB);
        rmem(2, v);  chk("R14 cell overwritten", v, 16'h27AB);
    endtask

    initial begin
        #(T * 190000);
        n_bad++;
        $display("FAIL R13 watchdog: got hang expected halt");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_sample_add();
        t_logic();
        t_jumps();
        t_loop();
        t_halt_freeze();
        t_self_modify();
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule